// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one channel of a memory-to-memory DMA engine. It walks a linked list of 16-byte descriptors. Each descriptor gives a source address, a target address and a command word. The channel moves the described bytes in bursts. Each burst first reads every unit from the source into a local burst buffer, then writes every unit to the target. A burst can start freely, or it can wait until a peripheral raises its request line.

Software loads the four descriptor words through a small write port while the channel is idle. It then pulses `run_i`, either with descriptor fetch enabled, so the channel loads the list from memory, or without it, so the channel runs once from the loaded words. Single-cycle strobes report a descriptor start, the end of a transfer, the end of a receive (request withdrawn) and the return to idle. The four descriptor words remain visible on output ports at all times.

Top module: `dchn_engine`

## Requirements
- R1: After reset the channel is idle. `running_o`, `mem_req_o` and all event strobes are low, and all four descriptor outputs read zero.
- R2: A fetch issues four 32-bit reads at consecutive word addresses, starting at the next-descriptor register with its low 4 bits forced to zero. The words land in this order: next-descriptor, source, target, command.
- R3: If bit 1 of the next-descriptor word is set and `cmp_i` is high at fetch time, the fetch starts 32 bytes above the aligned address.
- R4: Command word fields are as follows.
  - Bits 12:0 hold the byte length.
  - Bits 15:14 hold the unit code: 1 gives 1 byte, 2 gives 2 bytes, 3 gives 4 bytes, and 0 is treated as 1 byte.
  - Bits 17:16 hold the burst code s, for a burst of 4<<s bytes.
  - Each burst moves min(length, burst) bytes, reading all of its units before writing any of them.
- R5: The source address advances by the unit size after each unit only when command bit 31 is set. The target address does the same only when command bit 30 is set.
- R6: After each burst, the remaining length is written back into command bits 12:0.
- R7: `ev_start_o` pulses after a fetch whose command bit 22 is set. `ev_end_o` pulses when the length reaches zero while command bit 21 is set.
- R8: When the length reaches zero, the channel stops if `nofetch_i` is set, if bit 0 of the next-descriptor word is set, or if `eor_stop_i` is set. Stopping means `running_o` falls and `ev_stop_o` pulses. Otherwise the channel fetches the next descriptor.
- R9: Command bit 29 (source pacing) or bit 28 (target pacing) clears the low 2 bits of the matching address at fetch. While either bit is set, every burst waits with no memory access until `req_i` is high.
- R10: With pacing active, if `req_i` is low after a burst, `ev_eor_o` pulses. The channel then stops if `eor_stop_i` is set. Otherwise, if `eor_jump_i` is set and `nofetch_i` is clear, it fetches the next descriptor.
- R11: A `run_i` pulse with `nofetch_i` set starts transfers from the loaded registers without any descriptor read.
- R12: `reg_we_i` writes the word chosen by `reg_sel_i` (0 next, 1 source, 2 target, 3 command), but only while the channel is idle. While it runs, writes are ignored.
- R13: A memory request, once raised, keeps its address and direction unchanged until a cycle with `mem_ready_i` high completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Start pulse, accepted when idle |
| nofetch_i | input | 1 | Run from registers; stop at end of transfer |
| eor_stop_i | input | 1 | Stop on end of receive or end of transfer |
| eor_jump_i | input | 1 | Fetch the next descriptor on end of receive |
| cmp_i | input | 1 | Compare status, selects the branch target |
| req_i | input | 1 | Peripheral request level for paced bursts |
| reg_we_i | input | 1 | Descriptor register write strobe |
| reg_sel_i | input | 2 | Selects which descriptor word is written |
| reg_wdata_i | input | 32 | Descriptor write data |
| desc_next_o | output | 32 | Next-descriptor word |
| desc_src_o | output | 32 | Current source address |
| desc_dst_o | output | 32 | Current target address |
| desc_cmd_o | output | 32 | Command word with remaining length |
| running_o | output | 1 | Channel active |
| ev_start_o | output | 1 | Descriptor start event |
| ev_end_o | output | 1 | Transfer end event |
| ev_eor_o | output | 1 | End-of-receive event |
| ev_stop_o | output | 1 | Channel stopped event |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Byte address |
| mem_size_o | output | 2 | Access size, log2 of bytes |
| mem_wdata_o | output | 32 | Write data, unit in low bytes |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_ready_i | input | 1 | Completes the pending access |

## Verification
Four properties are checked on every cycle:
- a pending memory access keeps its address and direction until it completes;
- the stop strobe is never seen while the channel still runs;
- the descriptor words do not move in idle without a write;
- a paced burst without a request stays parked, and the start strobe only follows a fetch.

Some behaviours can only be shown by the bench's scenarios, because they need whole-transfer results and timed stimulus:
- the copied data for random unit, burst and increment settings;
- the byte counts left in the command word;
- where branching and end-of-receive jumps lead;
- that writes during a run are ignored.

// File: rtl/dchn_pkg.sv
package dchn_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W  = 13;

    // command word field positions
    localparam int F_UNIT      = 14;
    localparam int F_BURST     = 16;
    localparam int F_END_IE    = 21;
    localparam int F_START_IE  = 22;
    localparam int F_PACE_DST  = 28;
    localparam int F_PACE_SRC  = 29;
    localparam int F_INC_DST   = 30;
    localparam int F_INC_SRC   = 31;

    // next-descriptor word flags
    localparam int N_STOP   = 0;
    localparam int N_BRANCH = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_READ,
        ST_WRITE,
        ST_POST
    } dchn_state_e;
endpackage

// File: rtl/dchn_cmd_decode.sv
module dchn_cmd_decode
    import dchn_pkg::*;
#(
    parameter int BUF_BYTES = 32,
    localparam int OFF_W = $clog2(BUF_BYTES) + 1
) (
    input  logic [WORD_W-1:0] cmd_i,
    output logic [LEN_W-1:0]  len_o,
    output logic [2:0]        unit_o,
    output logic [1:0]        size_o,
    output logic [OFF_W-1:0]  burst_o,
    output logic              inc_src_o,
    output logic              inc_dst_o,
    output logic              paced_o
);
    logic [7:0] raw_burst;

    always_comb begin
        len_o     = cmd_i[LEN_W-1:0];
        inc_src_o = cmd_i[F_INC_SRC];
        inc_dst_o = cmd_i[F_INC_DST];
        paced_o   = cmd_i[F_PACE_SRC] | cmd_i[F_PACE_DST];
        unique case (cmd_i[F_UNIT+:2])
            2'd2:    begin unit_o = 3'd2; size_o = 2'd1; end
            2'd3:    begin unit_o = 3'd4; size_o = 2'd2; end
            default: begin unit_o = 3'd1; size_o = 2'd0; end
        endcase
        raw_burst = 8'd4 << cmd_i[F_BURST+:2];
        if (int'(raw_burst) > BUF_BYTES) burst_o = OFF_W'(BUF_BYTES);
        else                             burst_o = OFF_W'(raw_burst);
    end
endmodule

// File: rtl/dchn_burst_buf.sv
module dchn_burst_buf #(
    parameter int BUF_BYTES = 32,
    localparam int OFF_W = $clog2(BUF_BYTES) + 1,
    localparam int IDX_W = $clog2(BUF_BYTES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [OFF_W-1:0] wr_off_i,
    input  logic [2:0]       wr_bytes_i,
    input  logic [31:0]      wr_data_i,
    input  logic [OFF_W-1:0] rd_off_i,
    output logic [31:0]      rd_data_o
);
    logic [7:0] bytes_q [BUF_BYTES];

    for (genvar g = 0; g < BUF_BYTES; g++) begin : g_byte
        int         rel;
        logic       hit;
        logic [1:0] lane;
        always_comb begin
            rel  = g - int'(wr_off_i);
            hit  = (rel >= 0) && (rel < int'(wr_bytes_i));
            lane = rel[1:0];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)              bytes_q[g] <= 8'h00;
            else if (wr_en_i && hit)  bytes_q[g] <= wr_data_i[{lane, 3'b000} +: 8];
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < 4; k++) begin
            int idx;
            idx = int'(rd_off_i) + k;
            if (idx < BUF_BYTES) rd_data_o[8*k +: 8] = bytes_q[idx[IDX_W-1:0]];
        end
    end
endmodule

// File: rtl/dchn_engine.sv
module dchn_engine
    import dchn_pkg::*;
#(
    parameter int BUF_BYTES   = 32,
    parameter int BRANCH_SKIP = 32,
    localparam int OFF_W = $clog2(BUF_BYTES) + 1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        run_i,
    input  logic        nofetch_i,
    input  logic        eor_stop_i,
    input  logic        eor_jump_i,
    input  logic        cmp_i,
    input  logic        req_i,
    input  logic        reg_we_i,
    input  logic [1:0]  reg_sel_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] desc_next_o,
    output logic [31:0] desc_src_o,
    output logic [31:0] desc_dst_o,
    output logic [31:0] desc_cmd_o,
    output logic        running_o,
    output logic        ev_start_o,
    output logic        ev_end_o,
    output logic        ev_eor_o,
    output logic        ev_stop_o,
    output logic        mem_req_o,
    output logic        mem_we_o,
    output logic [31:0] mem_addr_o,
    output logic [1:0]  mem_size_o,
    output logic [31:0] mem_wdata_o,
    input  logic [31:0] mem_rdata_i,
    input  logic        mem_ready_i
);
    typedef struct packed {
        dchn_state_e        st;
        logic               running;
        logic [WORD_W-1:0]  nxt;
        logic [WORD_W-1:0]  src;
        logic [WORD_W-1:0]  dst;
        logic [WORD_W-1:0]  cmd;
        logic [WORD_W-1:0]  faddr;
        logic [1:0]         fidx;
        logic [OFF_W-1:0]   nbyte;
        logic [OFF_W-1:0]   burst;
        logic               ev_start;
        logic               ev_end;
        logic               ev_eor;
        logic               ev_stop;
    } dchn_regs_t;

    dchn_regs_t d, q;

    logic [LEN_W-1:0] len;
    logic [2:0]       unit;
    logic [1:0]       size;
    logic [OFF_W-1:0] burst_max;
    logic             inc_src, inc_dst, paced;
    logic             buf_we;
    logic [31:0]      buf_rdata;

    dchn_cmd_decode #(.BUF_BYTES(BUF_BYTES)) u_dec (
        .cmd_i(q.cmd), .len_o(len), .unit_o(unit), .size_o(size),
        .burst_o(burst_max), .inc_src_o(inc_src), .inc_dst_o(inc_dst), .paced_o(paced)
    );

    dchn_burst_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(buf_we), .wr_off_i(q.nbyte),
        .wr_bytes_i(unit), .wr_data_i(mem_rdata_i), .rd_off_i(q.nbyte), .rd_data_o(buf_rdata)
    );

    function automatic logic [31:0] fetch_base(input logic [31:0] nx, input logic cmp);
        fetch_base = {nx[31:4], 4'h0} + ((nx[N_BRANCH] && cmp) ? 32'(BRANCH_SKIP) : 32'd0);
    endfunction

    logic [LEN_W-1:0] new_len;
    logic [OFF_W-1:0] nb_next;
    logic             go_fetch, go_stop;

    always_comb begin
        d          = q;
        d.ev_start = 1'b0;
        d.ev_end   = 1'b0;
        d.ev_eor   = 1'b0;
        d.ev_stop  = 1'b0;
        mem_req_o  = 1'b0;
        mem_we_o   = 1'b0;
        mem_addr_o = '0;
        buf_we     = 1'b0;
        go_fetch   = 1'b0;
        go_stop    = 1'b0;
        new_len    = len - LEN_W'(q.burst);
        nb_next    = q.nbyte + OFF_W'(unit);

        unique case (q.st)
            ST_IDLE: begin
                if (reg_we_i) begin
                    unique case (reg_sel_i)
                        2'd0: d.nxt = reg_wdata_i;
                        2'd1: d.src = reg_wdata_i;
                        2'd2: d.dst = reg_wdata_i;
                        default: d.cmd = reg_wdata_i;
                    endcase
                end
                if (run_i) begin
                    d.running = 1'b1;
                    if (nofetch_i) d.st = ST_CHECK;
                    else           go_fetch = 1'b1;
                end
            end
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.faddr + {28'd0, q.fidx, 2'b00};
                if (mem_ready_i) begin
                    d.fidx = q.fidx + 2'd1;
                    unique case (q.fidx)
                        2'd0: d.nxt = mem_rdata_i;
                        2'd1: d.src = mem_rdata_i;
                        2'd2: d.dst = mem_rdata_i;
                        default: begin
                            d.cmd = mem_rdata_i;
                            if (mem_rdata_i[F_PACE_SRC]) d.src[1:0] = 2'b00;
                            if (mem_rdata_i[F_PACE_DST]) d.dst[1:0] = 2'b00;
                            d.ev_start = mem_rdata_i[F_START_IE];
                            d.st       = ST_CHECK;
                        end
                    endcase
                end
            end
            ST_CHECK: begin
                if (!paced || req_i) begin
                    d.nbyte = '0;
                    d.burst = (len < LEN_W'(burst_max)) ? OFF_W'(len) : burst_max;
                    d.st    = (len == '0) ? ST_POST : ST_READ;
                end
            end
            ST_READ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.src;
                if (mem_ready_i) begin
                    buf_we  = 1'b1;
                    d.src   = q.src + (inc_src ? 32'(unit) : 32'd0);
                    d.nbyte = nb_next;
                    if (nb_next >= q.burst) begin
                        d.nbyte = '0;
                        d.st    = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = q.dst;
                if (mem_ready_i) begin
                    d.dst   = q.dst + (inc_dst ? 32'(unit) : 32'd0);
                    d.nbyte = nb_next;
                    if (nb_next >= q.burst) d.st = ST_POST;
                end
            end
            default: begin // ST_POST
                d.cmd[LEN_W-1:0] = new_len;
                d.st             = ST_CHECK;
                if (new_len == '0 && q.cmd[F_END_IE]) d.ev_end = 1'b1;
                if (paced && !req_i) begin
                    d.ev_eor = 1'b1;
                    if (eor_stop_i)                    go_stop  = 1'b1;
                    else if (eor_jump_i && !nofetch_i) go_fetch = 1'b1;
                end
                if (!go_stop && !go_fetch && new_len == '0) begin
                    if (nofetch_i || q.nxt[N_STOP] || eor_stop_i) go_stop  = 1'b1;
                    else                                          go_fetch = 1'b1;
                end
            end
        endcase

        if (go_fetch) begin
            d.st    = ST_FETCH;
            d.fidx  = 2'd0;
            d.faddr = fetch_base(q.nxt, cmp_i);
        end
        if (go_stop) begin
            d.st      = ST_IDLE;
            d.running = 1'b0;
            d.ev_stop = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign desc_next_o = q.nxt;
    assign desc_src_o  = q.src;
    assign desc_dst_o  = q.dst;
    assign desc_cmd_o  = q.cmd;
    assign running_o   = q.running;
    assign ev_start_o  = q.ev_start;
    assign ev_end_o    = q.ev_end;
    assign ev_eor_o    = q.ev_eor;
    assign ev_stop_o   = q.ev_stop;
    assign mem_size_o  = (q.st == ST_FETCH) ? 2'd2 : size;
    assign mem_wdata_o = buf_rdata;

    // R13
    addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R8
    stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_stop_o |-> !running_o);

    // R12
    idle_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_IDLE && !reg_we_i) |=> ($stable(desc_cmd_o) && $stable(desc_next_o)
                                            && $stable(desc_src_o) && $stable(desc_dst_o)));

    // R9
    pace_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_CHECK && paced && !req_i) |=> (q.st == ST_CHECK && !mem_req_o));

    // R7
    start_after_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_start_o |-> $past(q.st == ST_FETCH));
endmodule

// File: tb/tb_dchn_engine.sv
module tb_dchn_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 0, nofetch = 0, eor_stop = 0, eor_jump = 0, cmp = 0, req = 0;
    logic        reg_we = 0;
    logic [1:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] desc_next, desc_src, desc_dst, desc_cmd;
    logic        running, ev_start, ev_end, ev_eor, ev_stop;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        mem_ready = 1'b0;

    int tests = 0, fails = 0, cycles = 0;
    bit done = 0;
    int n_start = 0, n_end = 0, n_eor = 0, n_stop = 0, rcnt = 0, wcnt = 0, hold_viol = 0;
    logic [7:0] mem [4096];
    logic [7:0] expm [4096];
    logic        pend_q = 0;
    logic [31:0] pend_addr = 0;

    always #4 clk = ~clk;

    dchn_engine dut (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run), .nofetch_i(nofetch), .eor_stop_i(eor_stop),
        .eor_jump_i(eor_jump), .cmp_i(cmp), .req_i(req), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
        .reg_wdata_i(reg_wdata), .desc_next_o(desc_next), .desc_src_o(desc_src),
        .desc_dst_o(desc_dst), .desc_cmd_o(desc_cmd), .running_o(running),
        .ev_start_o(ev_start), .ev_end_o(ev_end), .ev_eor_o(ev_eor), .ev_stop_o(ev_stop),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
    );

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            logic [11:0] a;
            a = mem_addr[11:0] + 12'(k);
            mem_rdata[8*k +: 8] = mem[a];
        end
    end

    always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (ev_start) n_start <= n_start + 1;
        if (ev_end)   n_end   <= n_end + 1;
        if (ev_eor)   n_eor   <= n_eor + 1;
        if (ev_stop)  n_stop  <= n_stop + 1;
        if (pend_q && (!mem_req || mem_addr != pend_addr)) hold_viol <= hold_viol + 1;
        pend_q    <= mem_req && !mem_ready;
        pend_addr <= mem_addr;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                wcnt <= wcnt + 1;
                for (int k = 0; k < (1 << mem_size); k++)
                    mem[mem_addr[11:0] + 12'(k)] <= mem_wdata[8*k +: 8];
            end else begin
                rcnt <= rcnt + 1;
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        wait (cycles > 150000);
        tests++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        summary();
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic chk_mem(input string tag);
        int bad = 0;
        for (int i = 0; i < 4096; i++) if (mem[i] !== expm[i]) bad++;
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic put_word(input logic [31:0] a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) begin
            mem[a[11:0] + 12'(k)]  = v[8*k +: 8];
            expm[a[11:0] + 12'(k)] = v[8*k +: 8];
        end
    endtask

    task automatic put_desc(input logic [31:0] a, nx, s, t, c);
        put_word(a, nx); put_word(a + 4, s); put_word(a + 8, t); put_word(a + 12, c);
    endtask

    // expected copy from the requirements (R4, R5)
    task automatic model_copy(input logic [31:0] s, input logic [31:0] t, input logic [31:0] c);
        int len = int'(c[12:0]);
        int w   = (c[15:14] == 2'd3) ? 4 : (c[15:14] == 2'd2) ? 2 : 1;
        int bs  = 4 << c[17:16];
        logic [7:0] b [36];
        while (len > 0) begin
            int n = (len < bs) ? len : bs;
            for (int o = 0; o < n; o += w) begin
                for (int k = 0; k < w; k++) b[o + k] = expm[s[11:0] + 12'(k)];
                if (c[31]) s += w;
            end
            for (int o = 0; o < n; o += w) begin
                for (int k = 0; k < w; k++) expm[t[11:0] + 12'(k)] = b[o + k];
                if (c[30]) t += w;
            end
            len -= n;
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = v;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic pulse_run();
        @(negedge clk); run = 1;
        @(negedge clk); run = 0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        repeat (2) @(negedge clk);
        while (running && n < 5000) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
        if (n >= 5000) chk(0, tag, 1, 0);
    endtask

    task automatic clr_counts();
        @(negedge clk);
        n_start = 0; n_end = 0; n_eor = 0; n_stop = 0; rcnt = 0; wcnt = 0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 8'($urandom); expm[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!running && !mem_req && !ev_start && !ev_end && !ev_eor && !ev_stop, "R1 idle outputs",
            {running, mem_req, ev_start, ev_stop}, 0);
        chk((desc_next | desc_src | desc_dst | desc_cmd) == 0, "R1 descriptor words", desc_cmd, 0);

        // no-fetch run from registers (R11, R12, R5, R6, R8)
        begin
            logic [31:0] c = 32'd20 | (32'd3 << 14) | (32'd1 << 16) | (32'd1 << 21) | (32'd3 << 30);
            wr_reg(0, 32'h0); wr_reg(1, 32'h100); wr_reg(2, 32'h300); wr_reg(3, c);
            chk(desc_cmd == c && desc_src == 32'h100, "R12 idle write readback", desc_cmd, c);
            model_copy(32'h100, 32'h300, c);
            clr_counts();
            nofetch = 1;
            pulse_run();
            wait_idle("R11 timeout");
            nofetch = 0;
            chk_mem("R4 copied bytes no-fetch");
            chk(rcnt == 5, "R11 no descriptor reads", rcnt, 5);
            chk(desc_cmd[12:0] == 0, "R6 length written back", desc_cmd[12:0], 0);
            chk(desc_src == 32'h114, "R5 source advanced", desc_src, 32'h114);
            chk(n_end == 1 && n_stop == 1 && n_start == 0, "R7 R8 strobes", {n_start, n_end, n_stop}, 32'h011);
        end

        // random two-descriptor chains (R2, R4, R5, R7, R8)
        for (int it = 0; it < 6; it++) begin
            logic [31:0] ca, cb, sa, ta, sb, tb;
            int wc = 1 + ($urandom % 3);
            int w = (wc == 3) ? 4 : wc;
            int ea = $urandom % 2, eb = $urandom % 2;
            ca = 32'(w * (1 + $urandom % 12)) | (32'(wc) << 14) | (32'($urandom % 4) << 16)
                 | (32'(ea) << 21) | (32'd1 << 22) | (32'($urandom % 4) << 30);
            cb = 32'(w * (1 + $urandom % 12)) | (32'(wc) << 14) | (32'($urandom % 4) << 16)
                 | (32'(eb) << 21) | (32'd1 << 22) | (32'($urandom % 4) << 30);
            sa = 32'h000 + ($urandom % 64); ta = 32'h400 + ($urandom % 64);
            sb = 32'h100 + ($urandom % 64); tb = 32'h500 + ($urandom % 64);
            put_desc(32'h800, 32'h810, sa, ta, ca);
            put_desc(32'h810, 32'h001, sb, tb, cb);
            model_copy(sa, ta, ca);
            model_copy(sb, tb, cb);
            wr_reg(0, 32'h80C);
            clr_counts();
            pulse_run();
            wait_idle("R2 timeout");
            chk_mem("R4 chain copy");
            chk(desc_next == 32'h001, "R2 second descriptor loaded", desc_next, 1);
            chk(desc_cmd[31:13] == cb[31:13] && desc_cmd[12:0] == 0, "R6 final command", desc_cmd, {cb[31:13], 13'd0});
            chk(n_start == 2 && n_end == ea + eb && n_stop == 1, "R7 R8 chain strobes",
                {n_start, n_end, n_stop}, {32'd2, 32'(ea + eb), 32'd1});
        end

        // branch on compare status (R3)
        put_desc(32'hA00, 32'h001, 32'h000, 32'h600, 32'd4 | (32'd3 << 14));
        put_desc(32'hA20, 32'h001, 32'h040, 32'h600, 32'd4 | (32'd3 << 14));
        model_copy(32'h040, 32'h600, 32'd4 | (32'd3 << 14));
        cmp = 1;
        wr_reg(0, 32'hA02);
        pulse_run();
        wait_idle("R3 timeout");
        chk(desc_src == 32'h040, "R3 branch taken", desc_src, 32'h040);
        chk_mem("R3 branch copy");
        cmp = 0;
        model_copy(32'h000, 32'h600, 32'd4 | (32'd3 << 14));
        wr_reg(0, 32'hA02);
        pulse_run();
        wait_idle("R3 timeout");
        chk(desc_src == 32'h000, "R3 branch not taken", desc_src, 32'h000);
        chk_mem("R3 linear copy");

        // paced transfer waits for request (R9, R12)
        begin
            logic [31:0] c = 32'd16 | (32'd3 << 14) | (32'd1 << 29) | (32'd3 << 30);
            put_desc(32'hB00, 32'h001, 32'h203, 32'h700, c);
            model_copy(32'h200, 32'h700, c);
            wr_reg(0, 32'hB00);
            clr_counts();
            req = 0;
            pulse_run();
            repeat (40) @(negedge clk);
            chk(running && wcnt == 0 && rcnt == 4, "R9 parked without request", rcnt, 4);
            chk(desc_src == 32'h200, "R9 low bits cleared", desc_src, 32'h200);
            wr_reg(3, 32'h0);
            chk(desc_cmd == c, "R12 write ignored while running", desc_cmd, c);
            req = 1;
            wait_idle("R9 timeout");
            chk_mem("R9 paced copy");
            chk(n_eor == 0 && n_stop == 1, "R10 no eor while request held", n_eor, 0);
        end

        // end-of-receive stop (R10)
        begin
            int n = 0;
            logic [31:0] c = 32'd16 | (32'd3 << 14) | (32'd1 << 29) | (32'd3 << 30);
            put_desc(32'hC00, 32'h000, 32'h240, 32'h740, c);
            model_copy(32'h240, 32'h740, 32'd4 | (32'd3 << 14) | (32'd3 << 30));
            wr_reg(0, 32'hC00);
            clr_counts();
            eor_stop = 1; req = 1;
            pulse_run();
            while (wcnt < 1 && n < 2000) begin @(negedge clk); n++; end
            req = 0;
            wait_idle("R10 timeout");
            eor_stop = 0;
            chk(n_eor == 1 && n_stop == 1 && !running, "R10 eor stop", {n_eor, n_stop}, {32'd1, 32'd1});
            chk(desc_cmd[12:0] == 12, "R10 remaining length", desc_cmd[12:0], 12);
            chk_mem("R10 partial copy");
        end

        // end-of-receive jump (R10, R5)
        begin
            int n = 0;
            logic [31:0] ca = 32'd16 | (32'd3 << 14) | (32'd1 << 22) | (32'd1 << 29) | (32'd3 << 30);
            logic [31:0] cb = 32'd8 | (32'd3 << 14) | (32'd1 << 16) | (32'd1 << 22) | (32'd3 << 30);
            put_desc(32'hD00, 32'hD10, 32'h2C0, 32'h7C0, ca);
            put_desc(32'hD10, 32'h001, 32'h300, 32'h780, cb);
            model_copy(32'h2C0, 32'h7C0, 32'd4 | (32'd3 << 14) | (32'd3 << 30));
            model_copy(32'h300, 32'h780, cb);
            wr_reg(0, 32'hD00);
            clr_counts();
            eor_jump = 1; req = 1;
            pulse_run();
            while (wcnt < 1 && n < 2000) begin @(negedge clk); n++; end
            req = 0;
            wait_idle("R10 timeout");
            eor_jump = 0;
            chk(n_eor == 1 && n_start == 2 && desc_next == 32'h001, "R10 eor jump",
                {n_eor, n_start}, {32'd1, 32'd2});
            chk(desc_src == 32'h308, "R5 source after jump", desc_src, 32'h308);
            chk_mem("R10 jump copy");
        end

        chk(hold_viol == 0, "R13 request held until ready", hold_viol, 0);
        summary();
    end
endmodule